// File: doc/BRIEF.md
# Watchdog Timer with Reset Cause

This block is a countdown supervisor clocked by the system clock. Software writes a reload value, picks what should happen when time runs out, and then sets the run bit. Setting the run bit copies the reload value into the down counter. From then on, software has to "kick" the timer by writing the kick address before the counter reaches zero. If the counter does reach zero, the block raises exactly one of three request lines, chosen by a 2-bit action field:

- a one-cycle reset request to the system reset controller;
- a level nonmaskable-interrupt request;
- a level general-purpose interrupt request.

When a reset request is raised, the block also sets a sticky cause flag. The flag is cleared only by power-on reset or by software. The system reset that the request triggers returns every other register to its idle state but leaves the flag alone. Software can therefore read the flag after the reset and learn that the watchdog caused it.

The register port is a plain synchronous write strobe with an address and write data. Read data is registered and follows the address one clock later. The block has two resets:

- a power-on reset that clears everything;
- the chip's system reset, which clears everything except the cause flag.

Top module: `sentinel_wdt`

## Requirements
- R1: After power-on reset every output is low, the run bit, the expired bit and the cause flag read 0, the action field reads 00, the count reads 0 and the reload register reads all ones.
- R2: A write to address 0 with bit 0 set while the timer is stopped loads the counter with the reload register (address 1) at that clock edge. The count is readable at address 2. Control-register fields: bit 0 run, bits 2:1 action, bit 3 expired, bit 4 cause, bit 5 pending-interrupt.
- R3: While running and not expired, the count drops by one per clock. While stopped, it holds its value.
- R4: With action 00, one clock after the count is seen at 0 while running, `rst_req_o` is high for exactly one cycle and the cause flag is set in the same cycle.
- R5: With action 01, expiry sets `nmi_o`. With action 10, expiry sets `irq_o`. Each is a level that stays high until it is cleared.
- R6: With action 11, expiry raises no output. The counter stops at 0 and the expired bit reads 1.
- R7: Any write to address 2 while running reloads the counter on that edge, clears the expired bit and drops `nmi_o` and `irq_o`.
- R8: A kick in the same cycle in which the counter sits at 0 wins: no action is raised.
- R9: A write to address 2 while stopped has no effect on the count.
- R10: The system reset clears the run bit, the action field, the reload register, the counter and all outputs, but keeps the cause flag. Power-on reset clears the flag. Writing 1 to control bit 4 clears the flag. Bus writes are ignored while the system reset is high.
- R11: Writing 1 to control bit 5 drops `nmi_o` and `irq_o`. The counter stays expired and raises nothing again until it is reloaded.
- R12: `rdata_o` shows the register selected by `addr_i` one clock later. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high, clears everything |
| sys_rst_i | input | 1 | System reset, synchronous, active high, keeps the cause flag |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 reload, 2 count/kick |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request |
| nmi_o | output | 1 | Level nonmaskable-interrupt request |
| irq_o | output | 1 | Level general-purpose interrupt request |

## Verification
The collision that matters is a kick landing in the very cycle the counter sits at zero, when the expiry decision is made. The bench lines it up by kicking, waiting exactly the reload count of idle clocks, and kicking again. It then checks that no request line rises and that the count restarts (R8). A second overlap is a system reset arriving while the cause flag is set: the bench expects the flag to survive while the run bit and the outputs clear. Both cases are judged by a behavioural model that steps once per clock and is compared with every output on each falling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ACT_RESET = 2'b00,
    ACT_NMI   = 2'b01,
    ACT_IRQ   = 2'b10,
    ACT_OFF   = 2'b11
  } wdt_act_e;

  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_LOAD  = 2'd1;
  localparam logic [1:0] ADR_COUNT = 2'd2;

  localparam int BIT_RUN    = 0;
  localparam int BIT_SEL    = 1;
  localparam int BIT_SPENT  = 3;
  localparam int BIT_CAUSE  = 4;
  localparam int BIT_PEND   = 5;
  localparam int CTRL_USED  = 6;

  localparam int N_LEVEL = 2;

  function automatic wdt_act_e level_code(input int idx);
    return (idx == 0) ? ACT_NMI : ACT_IRQ;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter logic [CNT_W-1:0] LOAD_INIT = '1
) (
  input  logic             clk,
  input  logic             por,
  input  logic             sys_rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic             run_q,
  output wdt_act_e         sel_q,
  output logic [CNT_W-1:0] load_q,
  output logic             start,
  output logic             kick,
  output logic             clr_pend,
  output logic             clr_cause
);

  logic wr_ok;
  logic hit_ctrl;
  logic hit_load;
  logic hit_count;

  always_comb begin
    wr_ok     = wr & ~sys_rst & ~por;
    hit_ctrl  = wr_ok & (addr == ADR_CTRL);
    hit_load  = wr_ok & (addr == ADR_LOAD);
    hit_count = wr_ok & (addr == ADR_COUNT);
    start     = hit_ctrl & wdata[BIT_RUN] & ~run_q;
    kick      = hit_count & run_q;
    clr_pend  = hit_ctrl & wdata[BIT_PEND];
    clr_cause = hit_ctrl & wdata[BIT_CAUSE];
  end

  always_ff @(posedge clk) begin
    if (por || sys_rst) begin
      run_q  <= 1'b0;
      sel_q  <= ACT_RESET;
      load_q <= LOAD_INIT;
    end else begin
      if (hit_ctrl) begin
        run_q <= wdata[BIT_RUN];
        sel_q <= wdt_act_e'(wdata[BIT_SEL +: 2]);
      end
      if (hit_load) begin
        load_q <= wdata;
      end
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  input  logic             start,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             spent_q,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;
  logic reload;

  always_comb begin
    at_zero = (cnt_q == ZERO);
    reload  = start | kick;
    fire    = ~rst & run & ~spent_q & at_zero & ~reload;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO;
      spent_q <= 1'b0;
    end else if (reload) begin
      cnt_q   <= load_val;
      spent_q <= 1'b0;
    end else if (run && !spent_q) begin
      if (!at_zero) begin
        cnt_q <= cnt_q - ONE;
      end else begin
        spent_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     por,
  input  logic     sys_rst,
  input  logic     fire,
  input  wdt_act_e sel,
  input  logic     start,
  input  logic     kick,
  input  logic     clr_pend,
  input  logic     clr_cause,
  output logic     rst_req_q,
  output logic     nmi_q,
  output logic     irq_q,
  output logic     cause_q
);

  logic [N_LEVEL-1:0] lvl_q;
  logic               lvl_drop;
  logic               take_reset;

  always_comb begin
    lvl_drop   = clr_pend | start | kick;
    take_reset = fire & (sel == ACT_RESET);
  end

  for (genvar g = 0; g < N_LEVEL; g++) begin : g_level
    always_ff @(posedge clk) begin
      if (por || sys_rst) begin
        lvl_q[g] <= 1'b0;
      end else if (fire && (sel == level_code(g))) begin
        lvl_q[g] <= 1'b1;
      end else if (lvl_drop) begin
        lvl_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por || sys_rst) begin
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= take_reset;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      cause_q <= 1'b0;
    end else if (take_reset) begin
      cause_q <= 1'b1;
    end else if (clr_cause) begin
      cause_q <= 1'b0;
    end
  end

  always_comb begin
    nmi_q = lvl_q[0];
    irq_q = lvl_q[1];
  end

endmodule

// File: rtl/sentinel_wdt.sv
module sentinel_wdt
  import wdt_pkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] LOAD_INIT = '1
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             sys_rst_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             rst_req_o,
  output logic             nmi_o,
  output logic             irq_o
);

  localparam int PAD_W = CNT_W - CTRL_USED;

  logic             any_rst;
  logic             run_q;
  wdt_act_e         sel_q;
  logic [CNT_W-1:0] load_q;
  logic             start;
  logic             kick;
  logic             clr_pend;
  logic             clr_cause;
  logic [CNT_W-1:0] cnt_q;
  logic             spent_q;
  logic             fire;
  logic             cause_q;
  logic [CNT_W-1:0] ctrl_view;
  logic [CNT_W-1:0] rd_next;

  assign any_rst = por_i | sys_rst_i;

  wdt_regs #(.CNT_W(CNT_W), .LOAD_INIT(LOAD_INIT)) u_regs (
    .clk       (clk_i),
    .por       (por_i),
    .sys_rst   (sys_rst_i),
    .wr        (wr_i),
    .addr      (addr_i),
    .wdata     (wdata_i),
    .run_q     (run_q),
    .sel_q     (sel_q),
    .load_q    (load_q),
    .start     (start),
    .kick      (kick),
    .clr_pend  (clr_pend),
    .clr_cause (clr_cause)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk_i),
    .rst      (any_rst),
    .run      (run_q),
    .load_val (load_q),
    .start    (start),
    .kick     (kick),
    .cnt_q    (cnt_q),
    .spent_q  (spent_q),
    .fire     (fire)
  );

  wdt_action u_action (
    .clk       (clk_i),
    .por       (por_i),
    .sys_rst   (sys_rst_i),
    .fire      (fire),
    .sel       (sel_q),
    .start     (start),
    .kick      (kick),
    .clr_pend  (clr_pend),
    .clr_cause (clr_cause),
    .rst_req_q (rst_req_o),
    .nmi_q     (nmi_o),
    .irq_q     (irq_o),
    .cause_q   (cause_q)
  );

  always_comb begin
    ctrl_view = {{PAD_W{1'b0}}, (nmi_o | irq_o), cause_q, spent_q, sel_q, run_q};
    unique case (addr_i)
      ADR_CTRL:  rd_next = ctrl_view;
      ADR_LOAD:  rd_next = load_q;
      ADR_COUNT: rd_next = cnt_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (any_rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= rd_next;
    end
  end

endmodule

// File: rtl/sentinel_wdt_chk.sv
module sentinel_wdt_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             por,
  input logic             sys_rst,
  input logic             wr,
  input logic [1:0]       addr,
  input logic             run_q,
  input wdt_act_e         sel_q,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_req,
  input logic             nmi,
  input logic             irq,
  input logic             cause
);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (por)
    rst_req |=> !rst_req);

  // R4
  cause_with_req_chk: assert property (@(posedge clk) disable iff (por)
    rst_req |-> cause);

  // R5
  single_level_chk: assert property (@(posedge clk) disable iff (por)
    !(nmi && irq));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (por)
    (run_q && cnt != '0 && !wr && !sys_rst) |=> (cnt == $past(cnt) - 1'b1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (por)
    (!run_q && !sys_rst && !(wr && addr == ADR_CTRL)) |=> $stable(cnt));

  // R10
  cause_keep_chk: assert property (@(posedge clk) disable iff (por)
    (sys_rst && cause) |=> cause);

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (por)
    (sel_q == ACT_OFF) |=> (!rst_req && !$rose(nmi) && !$rose(irq)));

endmodule

bind sentinel_wdt sentinel_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_i),
  .por     (por_i),
  .sys_rst (sys_rst_i),
  .wr      (wr_i),
  .addr    (addr_i),
  .run_q   (run_q),
  .sel_q   (sel_q),
  .cnt     (cnt_q),
  .rst_req (rst_req_o),
  .nmi     (nmi_o),
  .irq     (irq_o),
  .cause   (cause_q)
);

// File: tb/sentinel_wdt_bench.sv
module sentinel_wdt_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         por = 1'b1;
  logic         srst = 1'b0;
  logic         wr = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         rst_req, nmi, irq;

  int    vectors = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    armed = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  bit         m_run, m_done, m_nmi, m_irq, m_rreq, m_cause;
  bit [1:0]   m_sel;
  bit [31:0]  m_load, m_cnt, m_rdata;

  sentinel_wdt u_sentinel_wdt (
    .clk_i(clk), .por_i(por), .sys_rst_i(srst), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .nmi_o(nmi), .irq_o(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    bit [31:0] rd;
    bit wctrl, kick, start, fire;
    armed = 1;
    cycles++;
    if (por) begin
      m_run = 0; m_done = 0; m_nmi = 0; m_irq = 0; m_rreq = 0; m_cause = 0;
      m_sel = 0; m_load = 32'hFFFF_FFFF; m_cnt = 0; m_rdata = 0;
    end else if (srst) begin
      m_run = 0; m_done = 0; m_nmi = 0; m_irq = 0; m_rreq = 0;
      m_sel = 0; m_load = 32'hFFFF_FFFF; m_cnt = 0; m_rdata = 0;
    end else begin
      case (addr)
        2'd0: rd = {26'd0, m_nmi | m_irq, m_cause, m_done, m_sel, m_run};
        2'd1: rd = m_load;
        2'd2: rd = m_cnt;
        default: rd = 0;
      endcase
      wctrl = wr && addr == 2'd0;
      kick  = wr && addr == 2'd2 && m_run;
      start = wctrl && wdata[0] && !m_run;
      fire  = m_run && !m_done && m_cnt == 0 && !kick && !start;
      m_rreq = fire && m_sel == 2'd0;
      if (fire && m_sel == 2'd1) m_nmi = 1;
      else if ((wctrl && wdata[5]) || kick || start) m_nmi = 0;
      if (fire && m_sel == 2'd2) m_irq = 1;
      else if ((wctrl && wdata[5]) || kick || start) m_irq = 0;
      if (fire && m_sel == 2'd0) m_cause = 1;
      else if (wctrl && wdata[4]) m_cause = 0;
      if (start || kick) begin
        m_cnt = m_load; m_done = 0;
      end else if (m_run && !m_done) begin
        if (m_cnt != 0) m_cnt = m_cnt - 1;
        else m_done = 1;
      end
      if (wctrl) begin m_run = wdata[0]; m_sel = wdata[2:1]; end
      if (wr && addr == 2'd1) m_load = wdata;
      m_rdata = rd;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // R12 read path, R4/R5 outputs: compared every clock
  always @(negedge clk) begin
    if (armed && !done) begin
      cmp("rdata", rdata, m_rdata);
      cmp("rst_req", {31'd0, rst_req}, {31'd0, m_rreq});
      cmp("nmi", {31'd0, nmi}, {31'd0, m_nmi});
      cmp("irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(logic [1:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic look(logic [1:0] a);
    addr = a;
    idle(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    idle(3);
    por = 0;
    tag = "R1"; look(2'd1); look(2'd0); look(2'd2);
    cmp("reset ctrl", rdata, 32'd0);

    tag = "R2"; put(2'd1, 32'd5); put(2'd0, 32'h3); look(2'd2); // run, NMI
    tag = "R3"; idle(2); put(2'd0, 32'h2); look(2'd2); idle(3);  // stop, hold
    tag = "R9"; put(2'd2, 0); look(2'd2);

    tag = "R5"; put(2'd0, 32'h3); look(2'd0); idle(8);
    cmp("nmi level", {31'd0, nmi}, 32'd1);
    tag = "R11"; put(2'd0, 32'h23); idle(5); look(2'd0);
    cmp("nmi cleared", {31'd0, nmi}, 32'd0);

    tag = "R7"; put(2'd2, 0); put(2'd0, 32'h5); look(2'd2); idle(8);
    cmp("irq level", {31'd0, irq}, 32'd1);
    put(2'd2, 0); look(2'd0);
    cmp("irq dropped by kick", {31'd0, irq}, 32'd0);

    tag = "R8"; put(2'd1, 32'd3); put(2'd2, 0); idle(3); put(2'd2, 0); idle(2);
    cmp("no expiry on kick at zero", {31'd0, irq}, 32'd0);
    put(2'd1, 32'd0); put(2'd2, 0); put(2'd2, 0); put(2'd2, 0); idle(3);
    cmp("load zero expires", {31'd0, irq}, 32'd1);

    tag = "R4"; put(2'd0, 32'h0); put(2'd1, 32'd2); put(2'd0, 32'h1); look(2'd0); idle(3);
    tag = "R10"; srst = 1; idle(2); srst = 0; look(2'd0);
    cmp("cause kept", rdata & 32'h10, 32'h10);
    put(2'd0, 32'h10); look(2'd0);
    cmp("cause w1c", rdata & 32'h10, 32'h0);
    put(2'd1, 32'd1); put(2'd0, 32'h1); idle(4);
    por = 1; idle(1); por = 0; look(2'd0);
    cmp("cause cleared by por", rdata, 32'h0);

    tag = "R6"; put(2'd1, 32'd2); put(2'd0, 32'h7); idle(6); look(2'd0);
    cmp("off expired bit", rdata & 32'h3F, 32'h0F);
    look(2'd3);
    tag = "R12"; cmp("addr3 reads zero", rdata, 32'h0);
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

endmodule